// File: doc/BRIEF.md
# Load/Store Ordering Queue with Memory Disambiguation

This block holds in-flight memory operations of an out-of-order core in two age-ordered circular queues, one for stores and one for loads. Operations enter in program order with an age tag. Address generation later fills in each entry's address, and for stores its size and data. When the scheduler asks to issue a load, the block searches the older stores. It then grants the load with forwarded store data or with a cache request, or it refuses the load for now.

Memory-order mistakes are caught in two ways. When a store's address becomes known, it checks younger loads that have already issued. When a load issues, it checks younger loads to the same word that have already issued. In both cases the block reports the oldest offending load for replay and clears its issued state so it can issue again. Stores reach memory strictly in order, one per cycle, once they have been marked ready to retire. A flush naming an age tag drops every younger entry from both queues.

Addresses are compared at word granularity, using address bits above bit 1. Access size is coded 0 for byte, 1 for halfword and 2 for word. Age order between two tags a and b is decided by the sign bit of a-b taken modulo 2^TW: a is older when that bit is 1.

Top module: `lsq_disambig`

## Requirements
- R1: After reset both queues are empty (`sq_full`=0, `lq_full`=0), and `ld_resp`, `replay_valid` and `mem_wr_valid` are 0.
- R2: Allocation appends one entry per cycle in program order. A queue raises its full flag when it holds its depth (default 8). An allocation into a full queue is ignored. `ld_retire` frees the oldest load.
- R3: With `spec_mode`=0, a load request is answered one cycle later with `ld_resp`=1 and `ld_grant`=0 while any older store has no address yet.
- R4: A granted load whose word matches an older store with a known address takes its data from the youngest such older store. Stores younger than the load are never used. The response shows `ld_fwd`=1, `ld_data` set to that store's data and `ld_mem_req`=0.
- R5: If that youngest matching older store is not word-sized (size code 0 or 1), the load is refused (`ld_grant`=0) and nothing is forwarded.
- R6: A granted load with no matching older store raises `ld_mem_req`=1 with `ld_addr` set to the load's address and `ld_fwd`=0.
- R7: With `spec_mode`=1, a load may be granted past older stores whose addresses are unknown. When such a store's address arrives and matches the word of a younger issued load, `replay_valid`=1 with that load's tag follows one cycle later.
- R8: When a load issues and a younger load to the same word has already issued, that younger load is reported for replay in the same response cycle. Loads to different words raise no replay.
- R9: When several loads conflict in one cycle, `replay_tag` names the oldest of them.
- R10: A store is written to memory only after `st_ready` has marked it. Writes go strictly in queue order, one per cycle, and the first is visible two cycles after the mark.
- R11: `flush_valid` with `flush_tag` removes every entry younger than that tag from both queues and keeps the tagged entry and all older ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec_mode | input | 1 | 1 lets loads issue past stores with unknown addresses |
| alloc_valid | input | 1 | Allocate one memory operation |
| alloc_store | input | 1 | 1 store, 0 load |
| alloc_tag | input | TW | Age tag of the allocated operation |
| sq_full | output | 1 | Store queue holds SQ_D entries |
| lq_full | output | 1 | Load queue holds LQ_D entries |
| upd_valid | input | 1 | Address generation result valid |
| upd_store | input | 1 | Result belongs to a store |
| upd_tag | input | TW | Tag of the operation being updated |
| upd_addr | input | AW | Byte address |
| upd_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| upd_data | input | DW | Store data |
| ld_req | input | 1 | Request to issue a load |
| ld_tag | input | TW | Tag of the requested load |
| ld_resp | output | 1 | Response to the previous cycle's request |
| ld_grant | output | 1 | Load was issued |
| ld_fwd | output | 1 | Data comes from a store |
| ld_data | output | DW | Forwarded store word |
| ld_mem_req | output | 1 | Load must read the cache |
| ld_addr | output | AW | Load address |
| st_ready | input | 1 | Mark a store ready to retire |
| st_ready_tag | input | TW | Tag of the store being marked |
| ld_retire | input | 1 | Free the oldest load |
| flush_valid | input | 1 | Remove entries younger than flush_tag |
| flush_tag | input | TW | Flush boundary tag |
| replay_valid | output | 1 | A load must replay |
| replay_tag | output | TW | Tag of the load to replay |
| mem_wr_valid | output | 1 | Store write to memory |
| mem_wr_addr | output | AW | Write address |
| mem_wr_size | output | 2 | Write size code |
| mem_wr_data | output | DW | Write data |

## Verification
Every load response, forward and replay is registered. It appears on the clock edge that samples the request or the address update. Memory writes appear one edge after the edge that records the ready mark. The bench changes inputs 1 ns after a rising edge. It reads results 1 ns after the edge on which they are due: one edge after a load request or store address update, and two edges after a ready mark. The bench also samples the cycle before and the cycle after each due edge to show that an output is neither early nor sticky.

// File: rtl/lsq_disambig.sv
`timescale 1ns/1ps
module lsq_disambig #(
  parameter int SQ_D = 8,
  parameter int LQ_D = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spec_mode,
  input  logic          alloc_valid,
  input  logic          alloc_store,
  input  logic [TW-1:0] alloc_tag,
  output logic          sq_full,
  output logic          lq_full,
  input  logic          upd_valid,
  input  logic          upd_store,
  input  logic [TW-1:0] upd_tag,
  input  logic [AW-1:0] upd_addr,
  input  logic [1:0]    upd_size,
  input  logic [DW-1:0] upd_data,
  input  logic          ld_req,
  input  logic [TW-1:0] ld_tag,
  output logic          ld_resp,
  output logic          ld_grant,
  output logic          ld_fwd,
  output logic [DW-1:0] ld_data,
  output logic          ld_mem_req,
  output logic [AW-1:0] ld_addr,
  input  logic          st_ready,
  input  logic [TW-1:0] st_ready_tag,
  input  logic          ld_retire,
  input  logic          flush_valid,
  input  logic [TW-1:0] flush_tag,
  output logic          replay_valid,
  output logic [TW-1:0] replay_tag,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [1:0]    mem_wr_size,
  output logic [DW-1:0] mem_wr_data
);
  localparam int SQB = $clog2(SQ_D);
  localparam int LQB = $clog2(LQ_D);
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic older(input logic [TW-1:0] a, input logic [TW-1:0] b);
    logic [TW-1:0] d;
    d = a - b;
    return d[TW-1];
  endfunction

  logic [TW-1:0] sq_tag  [SQ_D];
  logic [AW-1:0] sq_addr [SQ_D];
  logic [1:0]    sq_size [SQ_D];
  logic [DW-1:0] sq_data [SQ_D];
  logic [SQ_D-1:0] sq_aok, sq_rdy, sq_live;
  logic [TW-1:0] lq_tag  [LQ_D];
  logic [AW-1:0] lq_addr [LQ_D];
  logic [LQ_D-1:0] lq_aok, lq_iss, lq_live;

  logic [SQB:0] sq_head, sq_tail, sq_cnt, sq_keep;
  logic [LQB:0] lq_head, lq_tail, lq_cnt, lq_keep;
  logic [SQB-1:0] sq_pos [SQ_D];
  logic [LQB-1:0] lq_pos [LQ_D];

  assign sq_cnt  = sq_tail - sq_head;
  assign lq_cnt  = lq_tail - lq_head;
  assign sq_full = sq_cnt == (SQB+1)'(SQ_D);
  assign lq_full = lq_cnt == (LQB+1)'(LQ_D);

  for (genvar g = 0; g < SQ_D; g++) begin : g_sq
    logic [SQB-1:0] off;
    assign off        = SQB'(g) - sq_head[SQB-1:0];
    assign sq_live[g] = {1'b0, off} < sq_cnt;
    assign sq_pos[g]  = sq_head[SQB-1:0] + SQB'(g);
  end
  for (genvar g = 0; g < LQ_D; g++) begin : g_lq
    logic [LQB-1:0] off;
    assign off        = LQB'(g) - lq_head[LQB-1:0];
    assign lq_live[g] = {1'b0, off} < lq_cnt;
    assign lq_pos[g]  = lq_head[LQB-1:0] + LQB'(g);
  end

  // locate the requested load
  logic lhit;
  logic [LQB-1:0] lidx;
  logic [AW-1:0] la;
  always_comb begin
    lhit = 1'b0;
    lidx = '0;
    for (int i = 0; i < LQ_D; i++)
      if (lq_live[i] && lq_tag[i] == ld_tag) begin
        lhit = 1'b1;
        lidx = LQB'(i);
      end
  end
  assign la = lq_addr[lidx];

  // scan older stores, oldest first, so the last match is the youngest
  logic unk, fhit;
  logic [SQB-1:0] fidx;
  always_comb begin
    unk  = 1'b0;
    fhit = 1'b0;
    fidx = '0;
    for (int k = 0; k < SQ_D; k++)
      if (sq_live[sq_pos[k]] && older(sq_tag[sq_pos[k]], ld_tag)) begin
        if (!sq_aok[sq_pos[k]]) unk = 1'b1;
        else if (sq_addr[sq_pos[k]][AW-1:2] == la[AW-1:2]) begin
          fhit = 1'b1;
          fidx = sq_pos[k];
        end
      end
  end

  logic issue_ok, st_upd, drain;
  assign issue_ok = ld_req && lhit && lq_aok[lidx] && !lq_iss[lidx] &&
                    (spec_mode || !unk) && (!fhit || sq_size[fidx] == SZ_WORD);
  assign st_upd   = upd_valid && upd_store;
  assign drain    = sq_cnt != '0 && sq_rdy[sq_head[SQB-1:0]] && sq_aok[sq_head[SQB-1:0]];

  // conflicting loads and the oldest of them
  logic [LQ_D-1:0] conf;
  logic [LQB-1:0] pick;
  always_comb begin
    for (int i = 0; i < LQ_D; i++) begin
      conf[i] = lq_live[i] && lq_aok[i] && (
        (issue_ok && lq_iss[i] && older(ld_tag, lq_tag[i]) &&
         lq_addr[i][AW-1:2] == la[AW-1:2]) ||
        (st_upd && (lq_iss[i] || (issue_ok && lidx == LQB'(i))) &&
         older(upd_tag, lq_tag[i]) && lq_addr[i][AW-1:2] == upd_addr[AW-1:2]));
    end
    pick = '0;
    for (int k = LQ_D - 1; k >= 0; k--)
      if (conf[lq_pos[k]]) pick = lq_pos[k];
  end

  always_comb begin
    sq_keep = '0;
    for (int i = 0; i < SQ_D; i++)
      if (sq_live[i] && !older(flush_tag, sq_tag[i])) sq_keep = sq_keep + 1'b1;
    lq_keep = '0;
    for (int i = 0; i < LQ_D; i++)
      if (lq_live[i] && !older(flush_tag, lq_tag[i])) lq_keep = lq_keep + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_head <= '0; sq_tail <= '0; lq_head <= '0; lq_tail <= '0;
      sq_aok <= '0; sq_rdy <= '0; lq_aok <= '0; lq_iss <= '0;
      for (int i = 0; i < SQ_D; i++) begin
        sq_tag[i] <= '0; sq_addr[i] <= '0; sq_size[i] <= '0; sq_data[i] <= '0;
      end
      for (int i = 0; i < LQ_D; i++) begin
        lq_tag[i] <= '0; lq_addr[i] <= '0;
      end
      ld_resp <= 1'b0; ld_grant <= 1'b0; ld_fwd <= 1'b0; ld_mem_req <= 1'b0;
      ld_data <= '0; ld_addr <= '0;
      replay_valid <= 1'b0; replay_tag <= '0;
      mem_wr_valid <= 1'b0; mem_wr_addr <= '0; mem_wr_size <= '0; mem_wr_data <= '0;
    end else begin
      ld_resp    <= ld_req;
      ld_grant   <= issue_ok;
      ld_fwd     <= issue_ok && fhit;
      ld_mem_req <= issue_ok && !fhit;
      ld_data    <= sq_data[fidx];
      ld_addr    <= la;
      replay_valid <= |conf;
      replay_tag   <= lq_tag[pick];

      if (issue_ok) lq_iss[lidx] <= 1'b1;
      for (int i = 0; i < LQ_D; i++) begin
        if (conf[i]) lq_iss[i] <= 1'b0;
        if (upd_valid && !upd_store && lq_live[i] && lq_tag[i] == upd_tag) begin
          lq_aok[i]  <= 1'b1;
          lq_addr[i] <= upd_addr;
        end
      end
      for (int i = 0; i < SQ_D; i++) begin
        if (st_upd && sq_live[i] && sq_tag[i] == upd_tag) begin
          sq_aok[i]  <= 1'b1;
          sq_addr[i] <= upd_addr;
          sq_size[i] <= upd_size;
          sq_data[i] <= upd_data;
        end
        if (st_ready && sq_live[i] && sq_tag[i] == st_ready_tag) sq_rdy[i] <= 1'b1;
      end

      mem_wr_valid <= drain;
      mem_wr_addr  <= sq_addr[sq_head[SQB-1:0]];
      mem_wr_size  <= sq_size[sq_head[SQB-1:0]];
      mem_wr_data  <= sq_data[sq_head[SQB-1:0]];
      if (drain) sq_head <= sq_head + 1'b1;
      if (ld_retire && lq_cnt != '0) lq_head <= lq_head + 1'b1;

      if (flush_valid) begin
        sq_tail <= sq_head + sq_keep;
        lq_tail <= lq_head + lq_keep;
      end else if (alloc_valid && alloc_store && !sq_full) begin
        sq_tag[sq_tail[SQB-1:0]] <= alloc_tag;
        sq_aok[sq_tail[SQB-1:0]] <= 1'b0;
        sq_rdy[sq_tail[SQB-1:0]] <= 1'b0;
        sq_tail <= sq_tail + 1'b1;
      end else if (alloc_valid && !alloc_store && !lq_full) begin
        lq_tag[lq_tail[LQB-1:0]] <= alloc_tag;
        lq_aok[lq_tail[LQB-1:0]] <= 1'b0;
        lq_iss[lq_tail[LQB-1:0]] <= 1'b0;
        lq_tail <= lq_tail + 1'b1;
      end
    end
  end

  // R2
  sq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_cnt <= (SQB+1)'(SQ_D) && lq_cnt <= (LQB+1)'(LQ_D));
  // R4
  fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd |-> ld_grant && !ld_mem_req);
  // R6
  memreq_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mem_req |-> ld_grant && ld_resp);
  // R7
  replay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(ld_req || st_upd));
  // R11
  flush_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> sq_cnt <= $past(sq_cnt) && lq_cnt <= $past(lq_cnt));
  // R10
  drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> $past(sq_cnt) != '0);
endmodule

// File: tb/tb_lsq_disambig.sv
`timescale 1ns/1ps
module tb_lsq_disambig;
  logic clk = 1'b0, rst_n = 1'b0, spec_mode = 1'b0;
  logic alloc_valid = 0, alloc_store = 0; logic [5:0] alloc_tag = '0;
  logic sq_full, lq_full;
  logic upd_valid = 0, upd_store = 0; logic [5:0] upd_tag = '0;
  logic [31:0] upd_addr = '0, upd_data = '0; logic [1:0] upd_size = '0;
  logic ld_req = 0; logic [5:0] ld_tag = '0;
  logic ld_resp, ld_grant, ld_fwd, ld_mem_req;
  logic [31:0] ld_data, ld_addr;
  logic st_ready = 0; logic [5:0] st_ready_tag = '0;
  logic ld_retire = 0, flush_valid = 0; logic [5:0] flush_tag = '0;
  logic replay_valid; logic [5:0] replay_tag;
  logic mem_wr_valid; logic [31:0] mem_wr_addr, mem_wr_data; logic [1:0] mem_wr_size;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lsq_disambig dut (.*);

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 0; spec_mode = 0; alloc_valid = 0; upd_valid = 0; ld_req = 0;
    st_ready = 0; ld_retire = 0; flush_valid = 0;
    step(); rst_n = 1; step();
  endtask

  task automatic alloc(bit st, logic [5:0] tag);
    alloc_valid = 1; alloc_store = st; alloc_tag = tag; step(); alloc_valid = 0;
  endtask

  task automatic upd(bit st, logic [5:0] tag, logic [31:0] a, logic [1:0] sz, logic [31:0] d);
    upd_valid = 1; upd_store = st; upd_tag = tag; upd_addr = a; upd_size = sz; upd_data = d;
    step(); upd_valid = 0;
  endtask

  task automatic issue(logic [5:0] tag);
    ld_req = 1; ld_tag = tag; step(); ld_req = 0;
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1", "sq_full", sq_full, 0);
    chk("R1", "lq_full", lq_full, 0);
    chk("R1", "ld_resp", ld_resp, 0);
    chk("R1", "replay_valid", replay_valid, 0);
    chk("R1", "mem_wr_valid", mem_wr_valid, 0);
  endtask

  task automatic t_conservative();
    reset_dut();
    alloc(1, 0); alloc(0, 1);
    upd(0, 1, 32'h100, 2, 0);
    issue(1);
    chk("R3", "resp", ld_resp, 1);
    chk("R3", "grant blocked", ld_grant, 0);
    upd(1, 0, 32'h200, 2, 32'hAAAA);
    issue(1);
    chk("R6", "grant", ld_grant, 1);
    chk("R6", "mem_req", ld_mem_req, 1);
    chk("R6", "fwd", ld_fwd, 0);
    chk("R6", "addr", ld_addr, 32'h100);
  endtask

  task automatic t_forward();
    reset_dut();
    alloc(1, 0); alloc(1, 1); alloc(0, 2); alloc(1, 3);
    upd(1, 0, 32'h40, 2, 32'h1111);
    upd(1, 1, 32'h40, 2, 32'h2222);
    upd(1, 3, 32'h40, 2, 32'h3333);
    upd(0, 2, 32'h42, 1, 0);
    issue(2);
    chk("R4", "grant", ld_grant, 1);
    chk("R4", "fwd", ld_fwd, 1);
    chk("R4", "data youngest older", ld_data, 32'h2222);
    chk("R4", "no mem_req", ld_mem_req, 0);
  endtask

  task automatic t_narrow();
    reset_dut();
    alloc(1, 0); alloc(0, 1);
    upd(1, 0, 32'h80, 1, 32'h5555);
    upd(0, 1, 32'h81, 0, 0);
    issue(1);
    chk("R5", "resp", ld_resp, 1);
    chk("R5", "grant refused", ld_grant, 0);
    chk("R5", "no fwd", ld_fwd, 0);
  endtask

  task automatic t_spec();
    reset_dut();
    spec_mode = 1;
    alloc(1, 0); alloc(0, 1); alloc(0, 2);
    upd(0, 1, 32'h300, 2, 0);
    upd(0, 2, 32'h400, 2, 0);
    issue(1);
    chk("R7", "grant past unknown", ld_grant, 1);
    issue(2);
    chk("R7", "second grant", ld_grant, 1);
    chk("R7", "no replay yet", replay_valid, 0);
    upd(1, 0, 32'h300, 2, 32'h77);
    chk("R7", "replay", replay_valid, 1);
    chk("R7", "replay tag", replay_tag, 1);
    step();
    chk("R7", "replay single cycle", replay_valid, 0);
  endtask

  task automatic t_oldest();
    reset_dut();
    spec_mode = 1;
    alloc(1, 0); alloc(0, 1); alloc(0, 2); alloc(0, 3);
    upd(0, 1, 32'h500, 2, 0);
    upd(0, 2, 32'h502, 1, 0);
    upd(0, 3, 32'h600, 2, 0);
    issue(1); issue(2); issue(3);
    chk("R9", "no load-load trap in order", replay_valid, 0);
    upd(1, 0, 32'h500, 2, 32'h9);
    chk("R9", "replay", replay_valid, 1);
    chk("R9", "oldest tag", replay_tag, 1);
  endtask

  task automatic t_loadload();
    reset_dut();
    alloc(0, 0); alloc(0, 1);
    upd(0, 0, 32'h700, 2, 0);
    upd(0, 1, 32'h700, 2, 0);
    issue(1);
    chk("R8", "younger grant", ld_grant, 1);
    issue(0);
    chk("R8", "older grant", ld_grant, 1);
    chk("R8", "trap", replay_valid, 1);
    chk("R8", "trap tag", replay_tag, 1);
    reset_dut();
    alloc(0, 0); alloc(0, 1);
    upd(0, 0, 32'h700, 2, 0);
    upd(0, 1, 32'h704, 2, 0);
    issue(1); issue(0);
    chk("R8", "different word no trap", replay_valid, 0);
  endtask

  task automatic t_drain();
    reset_dut();
    alloc(1, 0); alloc(1, 1);
    upd(1, 0, 32'h10, 2, 32'hA0);
    upd(1, 1, 32'h14, 2, 32'hA1);
    step(); step();
    chk("R10", "no write before ready", mem_wr_valid, 0);
    st_ready = 1; st_ready_tag = 1; step(); st_ready = 0; step();
    chk("R10", "younger ready waits", mem_wr_valid, 0);
    st_ready = 1; st_ready_tag = 0; step(); st_ready = 0;
    chk("R10", "not one cycle early", mem_wr_valid, 0);
    step();
    chk("R10", "first write", mem_wr_valid, 1);
    chk("R10", "first addr", mem_wr_addr, 32'h10);
    chk("R10", "first data", mem_wr_data, 32'hA0);
    step();
    chk("R10", "second write", mem_wr_valid, 1);
    chk("R10", "second addr", mem_wr_addr, 32'h14);
    step();
    chk("R10", "queue drained", mem_wr_valid, 0);
  endtask

  task automatic t_full();
    reset_dut();
    for (int i = 0; i < 8; i++) alloc(0, 6'(i));
    chk("R2", "lq full", lq_full, 1);
    alloc(0, 8);
    chk("R2", "ignored alloc keeps full", lq_full, 1);
    ld_retire = 1; step(); ld_retire = 0;
    chk("R2", "retire frees", lq_full, 0);
    alloc(0, 9);
    chk("R2", "refill", lq_full, 1);
  endtask

  task automatic t_flush();
    reset_dut();
    for (int i = 0; i < 8; i++) alloc(i % 2 == 0, 6'(i));
    flush_valid = 1; flush_tag = 3; step(); flush_valid = 0;
    for (int i = 0; i < 5; i++) alloc(1, 6'(4 + i));
    chk("R11", "sq after flush +5", sq_full, 0);
    alloc(1, 9);
    chk("R11", "sq after flush +6", sq_full, 1);
    for (int i = 0; i < 5; i++) alloc(0, 6'(10 + i));
    chk("R11", "lq after flush +5", lq_full, 0);
    alloc(0, 15);
    chk("R11", "lq after flush +6", lq_full, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_conservative();
    t_forward();
    t_narrow();
    t_spec();
    t_oldest();
    t_loadload();
    t_drain();
    t_full();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule